// File: doc/BRIEF.md
# Byte-wide programmable ROM burn sequencer

This block drives the parallel pins of a byte-wide, electrically erasable programmable ROM from the host side and writes a whole memory image into it. After a start request it raises both supply-select flags, then visits every address from zero upward. At each address it fetches the wanted byte from an image store and drives it onto the device bus. It fires a timed low strobe on the program pin, then releases the bus and reads the byte back through the output enable. If the read-back differs, it fires another strobe. There is a bound on the number of strobes per byte. When it runs out, the whole run stops with a fail result.

Once the last address verifies, the block lowers the programming supply to its normal level. It then reads every byte again and compares it with the image. The run ends with a fail on the first mismatch and with a pass otherwise. All pulse widths and setup times are given as microsecond parameters and are converted to clock cycles through a clock frequency parameter.

The image store sits behind a request/response port. A request carries an address on `img_req_valid`/`img_req_addr` and is taken when `img_req_ready` is high at a clock edge. Until then, `img_req_valid` stays high and `img_req_addr` stays stable. Only one request is outstanding at a time. The response is taken on an edge where both `img_rsp_valid` and `img_rsp_ready` are high. `img_rsp_ready` is high only while the block waits for that response. The store may hold back either side for any number of cycles, and the sequencer simply waits.

Top module: `rom_burn_seq`

## Requirements
- R1: During and right after reset the chip-enable, output-enable and strobe pins are high (inactive, active-low encoding), both supply flags are 0, the bus is not driven, `done` and `pass` are 0 and no image request is made.
- R2: The strobe falls only when the programming-supply flag (`sup_vpp_hi`=1 selects the high level) and the core-supply flag are both 1. Before each fall, the address, output data, bus drive, supply flags and chip enable have all been unchanged for at least SETUP_US*CLK_MHZ cycles.
- R3: Each strobe stays low for exactly PULSE_US*CLK_MHZ cycles, with chip enable low and output enable high during the whole pulse.
- R4: After each strobe rises, the same data stays driven on the bus for at least HOLD_US*CLK_MHZ cycles.
- R5: Whenever output enable is low, the bus is released. The device data is sampled only after output enable has been low for OE_DLY_CYC cycles.
- R6: A matching read-back moves the block to the next address and restarts the pulse count from zero. A mismatch gives another strobe at the same address. After a pass, every byte in the device equals the image.
- R7: An address that still mismatches after MAX_PULSES strobes ends the run with `pass`=0, and no further address is programmed.
- R8: Addresses are programmed in ascending order from 0 to 2**ADDR_W-1.
- R9: After the last address verifies, `sup_vpp_hi` drops to 0 and every byte is read once more, from address 0 upward. The first mismatch ends the run with `pass`=0. If every byte matches, the run ends with `pass`=1.
- R10: `done` rises when a run ends and stays high, with `pass` valid, until the next start. A start while a run is active has no effect.
- R11: An image request that is not yet accepted keeps `img_req_valid` high and `img_req_addr` stable on the next cycle.
- R12: When a run ends, both supply flags drop to 0, chip enable, output enable and the strobe are high, and the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run (taken only when idle) |
| done | output | 1 | Run finished; held until next start |
| pass | output | 1 | Result of the finished run |
| img_req_valid | output | 1 | Image read request valid |
| img_req_ready | input | 1 | Image store accepts request |
| img_req_addr | output | ADDR_W | Image address requested |
| img_rsp_valid | input | 1 | Image byte valid |
| img_rsp_ready | output | 1 | Sequencer waits for image byte |
| img_rsp_data | input | DATA_W | Image byte |
| dev_addr | output | ADDR_W | Device address pins |
| dev_dout | output | DATA_W | Data driven onto device bus |
| dev_dout_en | output | 1 | 1 = host drives the device bus |
| dev_din | input | DATA_W | Data read from device bus |
| dev_ce_n | output | 1 | Device chip enable, active low |
| dev_oe_n | output | 1 | Device output enable, active low |
| dev_pgm_n | output | 1 | Device program strobe, active low |
| sup_vpp_hi | output | 1 | 1 = programming supply at high level |
| sup_vdd_prog | output | 1 | 1 = core supply at programming level |

## Verification
The bench sweeps every address of an eight-byte device through a device model that needs a set number of strobes per address before a byte takes. This model tells apart a block that pulses once blindly, one that retries too often or not enough, and one that stops at the wrong count. The required strobe counts tried are one everywhere, a ramp of one to eight, exactly the limit at one address, and one more than the limit at one address. Together these separate the pass and fail boundary of the retry bound. A further case has one cell that reads wrong only at the lowered supply, so only the final compare can catch it. The device returns inverted data until output enable has been low long enough, so sampling too early shows up as extra strobes. The image store holds back requests on a fixed rhythm, which checks that requests stay stable while they wait.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  // Sequencer phases; program phase first, compare phase after.
  typedef enum logic [3:0] {
    S_IDLE,
    S_PWR,
    S_FETCH,
    S_SETUP,
    S_PULSE,
    S_HOLD,
    S_VFY,
    S_DROP,
    S_CFETCH,
    S_CRD
  } seq_st_t;

  typedef enum logic [1:0] {
    P_IDLE,
    P_REQ,
    P_WAIT
  } port_st_t;

endpackage

// File: rtl/rbs_delay.sv
// Down-counter shared by every timed phase of the sequencer.
module rbs_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/rbs_img_port.sv
// One-outstanding request/response fetch from the image store.
module rbs_img_port
  import rbs_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              got,
  output logic [DATA_W-1:0] byte_q,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data
);

  port_st_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= P_IDLE;
      req_addr <= '0;
      byte_q   <= '0;
      got      <= 1'b0;
    end else begin
      got <= 1'b0;
      case (st)
        P_IDLE: if (fetch) begin
          req_addr <= fetch_addr;
          st       <= P_REQ;
        end
        P_REQ: if (req_ready) st <= P_WAIT;
        P_WAIT: if (rsp_valid) begin
          byte_q <= rsp_data;
          got    <= 1'b1;
          st     <= P_IDLE;
        end
        default: st <= P_IDLE;
      endcase
    end
  end

  assign req_valid = (st == P_REQ);
  assign rsp_ready = (st == P_WAIT);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

endmodule

// File: rtl/rbs_ctrl.sv
// Program / verify / compare sequencing and device pin decode.
module rbs_ctrl
  import rbs_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 8,
  parameter int PULSE_CYC  = 5000,
  parameter int SETUP_CYC  = 100,
  parameter int HOLD_CYC   = 100,
  parameter int OE_DLY_CYC = 8,
  parameter int MAX_PULSES = 25,
  parameter int TMR_W      = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              pass,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] want,
  input  logic              got,
  output logic              fetch,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              tmr_zero,
  output logic              tmr_load,
  output logic [TMR_W-1:0]  tmr_val,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [DATA_W-1:0] dev_dout,
  output logic              dev_dout_en,
  output logic              dev_ce_n,
  output logic              dev_oe_n,
  output logic              dev_pgm_n,
  output logic              sup_vpp_hi,
  output logic              sup_vdd_prog
);

  localparam int PC_W = $clog2(MAX_PULSES + 1);
  localparam int LW_W = $clog2(PULSE_CYC + 2);
  localparam logic [ADDR_W-1:0] LAST_A   = {ADDR_W{1'b1}};
  localparam logic [PC_W-1:0]   LIMIT    = PC_W'(MAX_PULSES);
  localparam logic [TMR_W-1:0]  LD_SETUP = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0]  LD_PULSE = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0]  LD_HOLD  = TMR_W'(HOLD_CYC - 1);
  localparam logic [TMR_W-1:0]  LD_OE    = TMR_W'(OE_DLY_CYC - 1);

  seq_st_t           st, st_nx;
  logic [ADDR_W-1:0] addr, addr_nx;
  logic [PC_W-1:0]   pulses, pulses_nx;
  logic              done_q, done_nx, pass_q, pass_nx;
  logic              match;

  assign match = (din == want);

  always_comb begin
    st_nx     = st;
    addr_nx   = addr;
    pulses_nx = pulses;
    done_nx   = done_q;
    pass_nx   = pass_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    fetch     = 1'b0;
    case (st)
      S_IDLE: if (start) begin
        st_nx     = S_PWR;
        addr_nx   = '0;
        pulses_nx = '0;
        done_nx   = 1'b0;
        pass_nx   = 1'b0;
        tmr_load  = 1'b1;
        tmr_val   = LD_SETUP;
      end
      S_PWR: if (tmr_zero) begin
        st_nx = S_FETCH;
        fetch = 1'b1;
      end
      S_FETCH: if (got) begin
        st_nx    = S_SETUP;
        tmr_load = 1'b1;
        tmr_val  = LD_SETUP;
      end
      S_SETUP: if (tmr_zero) begin
        st_nx     = S_PULSE;
        pulses_nx = pulses + 1'b1;
        tmr_load  = 1'b1;
        tmr_val   = LD_PULSE;
      end
      S_PULSE: if (tmr_zero) begin
        st_nx    = S_HOLD;
        tmr_load = 1'b1;
        tmr_val  = LD_HOLD;
      end
      S_HOLD: if (tmr_zero) begin
        st_nx    = S_VFY;
        tmr_load = 1'b1;
        tmr_val  = LD_OE;
      end
      S_VFY: if (tmr_zero) begin
        if (match) begin
          pulses_nx = '0;
          if (addr == LAST_A) begin
            st_nx    = S_DROP;
            addr_nx  = '0;
            tmr_load = 1'b1;
            tmr_val  = LD_SETUP;
          end else begin
            st_nx   = S_FETCH;
            addr_nx = addr + 1'b1;
            fetch   = 1'b1;
          end
        end else if (pulses == LIMIT) begin
          st_nx   = S_IDLE;
          done_nx = 1'b1;
          pass_nx = 1'b0;
        end else begin
          st_nx    = S_SETUP;
          tmr_load = 1'b1;
          tmr_val  = LD_SETUP;
        end
      end
      S_DROP: if (tmr_zero) begin
        st_nx = S_CFETCH;
        fetch = 1'b1;
      end
      S_CFETCH: if (got) begin
        st_nx    = S_CRD;
        tmr_load = 1'b1;
        tmr_val  = LD_OE;
      end
      S_CRD: if (tmr_zero) begin
        if (!match) begin
          st_nx   = S_IDLE;
          done_nx = 1'b1;
          pass_nx = 1'b0;
        end else if (addr == LAST_A) begin
          st_nx   = S_IDLE;
          done_nx = 1'b1;
          pass_nx = 1'b1;
        end else begin
          st_nx   = S_CFETCH;
          addr_nx = addr + 1'b1;
          fetch   = 1'b1;
        end
      end
      default: st_nx = S_IDLE;
    endcase
  end

  assign fetch_addr = addr_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr   <= '0;
      pulses <= '0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      st     <= st_nx;
      addr   <= addr_nx;
      pulses <= pulses_nx;
      done_q <= done_nx;
      pass_q <= pass_nx;
    end
  end

  // Pin decode from the registered phase.
  assign done         = done_q;
  assign pass         = pass_q;
  assign dev_addr     = addr;
  assign dev_dout     = want;
  assign dev_dout_en  = (st == S_SETUP) || (st == S_PULSE) || (st == S_HOLD);
  assign dev_pgm_n    = (st != S_PULSE);
  assign dev_oe_n     = !((st == S_VFY) || (st == S_CRD));
  assign dev_ce_n     = !(dev_dout_en || (st == S_VFY) || (st == S_CFETCH) || (st == S_CRD));
  assign sup_vpp_hi   = (st == S_PWR) || (st == S_FETCH) || dev_dout_en || (st == S_VFY);
  assign sup_vdd_prog = (st != S_IDLE);

  // Strobe-low length tracker used only by the checks below.
  logic [LW_W-1:0] low_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_len <= '0;
    else if (!dev_pgm_n) low_len <= low_len + 1'b1;
    else                 low_len <= '0;
  end

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_pgm_n) |-> (low_len == LW_W'(PULSE_CYC)));

  // R3
  strobe_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_pgm_n |-> (dev_oe_n && !dev_ce_n && dev_dout_en));

  // R2
  strobe_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_pgm_n |-> (sup_vpp_hi && sup_vdd_prog));

  // R4
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_pgm_n) |-> (dev_dout_en && $stable(dev_dout) && $stable(dev_addr)));

  // R5
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_oe_n |-> !dev_dout_en);

  // R7
  pulse_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_pgm_n) |-> (pulses <= LIMIT));

  // R12
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (dev_ce_n && dev_oe_n && dev_pgm_n && !sup_vpp_hi && !sup_vdd_prog && !dev_dout_en));

endmodule

// File: rtl/rom_burn_seq.sv
module rom_burn_seq
  import rbs_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 8,
  parameter int CLK_MHZ    = 50,
  parameter int PULSE_US   = 100,
  parameter int SETUP_US   = 2,
  parameter int HOLD_US    = 2,
  parameter int OE_DLY_CYC = 8,
  parameter int MAX_PULSES = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              pass,
  output logic              img_req_valid,
  input  logic              img_req_ready,
  output logic [ADDR_W-1:0] img_req_addr,
  input  logic              img_rsp_valid,
  output logic              img_rsp_ready,
  input  logic [DATA_W-1:0] img_rsp_data,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [DATA_W-1:0] dev_dout,
  output logic              dev_dout_en,
  input  logic [DATA_W-1:0] dev_din,
  output logic              dev_ce_n,
  output logic              dev_oe_n,
  output logic              dev_pgm_n,
  output logic              sup_vpp_hi,
  output logic              sup_vdd_prog
);

  localparam int PULSE_CYC = CLK_MHZ * PULSE_US;
  localparam int SETUP_CYC = CLK_MHZ * SETUP_US;
  localparam int HOLD_CYC  = CLK_MHZ * HOLD_US;
  localparam int MAX_A     = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int MAX_B     = (HOLD_CYC > OE_DLY_CYC) ? HOLD_CYC : OE_DLY_CYC;
  localparam int MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W     = $clog2(MAX_CYC + 1);

  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic              fetch, got;
  logic [ADDR_W-1:0] fetch_addr;
  logic [DATA_W-1:0] want;

  rbs_delay #(.W(TMR_W)) u_delay (
    .clk  (clk),
    .rst_n(rst_n),
    .load (tmr_load),
    .val  (tmr_val),
    .zero (tmr_zero)
  );

  rbs_img_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch     (fetch),
    .fetch_addr(fetch_addr),
    .got       (got),
    .byte_q    (want),
    .req_valid (img_req_valid),
    .req_ready (img_req_ready),
    .req_addr  (img_req_addr),
    .rsp_valid (img_rsp_valid),
    .rsp_ready (img_rsp_ready),
    .rsp_data  (img_rsp_data)
  );

  rbs_ctrl #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PULSE_CYC (PULSE_CYC),
    .SETUP_CYC (SETUP_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .OE_DLY_CYC(OE_DLY_CYC),
    .MAX_PULSES(MAX_PULSES),
    .TMR_W     (TMR_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .done        (done),
    .pass        (pass),
    .din         (dev_din),
    .want        (want),
    .got         (got),
    .fetch       (fetch),
    .fetch_addr  (fetch_addr),
    .tmr_zero    (tmr_zero),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .dev_addr    (dev_addr),
    .dev_dout    (dev_dout),
    .dev_dout_en (dev_dout_en),
    .dev_ce_n    (dev_ce_n),
    .dev_oe_n    (dev_oe_n),
    .dev_pgm_n   (dev_pgm_n),
    .sup_vpp_hi  (sup_vpp_hi),
    .sup_vdd_prog(sup_vdd_prog)
  );

endmodule

// File: tb/rom_burn_seq_test.sv
module rom_burn_seq_test;

  localparam int AW = 3, DW = 8, N = 8;
  localparam int CLK_MHZ = 2, PULSE_US = 100, SETUP_US = 2, HOLD_US = 2;
  localparam int OE_DLY = 3, MAXP = 25;
  localparam int PCYC = CLK_MHZ * PULSE_US;
  localparam int SCYC = CLK_MHZ * SETUP_US;
  localparam int HCYC = CLK_MHZ * HOLD_US;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic done, pass;
  logic img_req_valid, img_req_ready = 1'b0, img_rsp_valid = 1'b0, img_rsp_ready;
  logic [AW-1:0] img_req_addr, dev_addr;
  logic [DW-1:0] img_rsp_data = '0, dev_dout, dev_din;
  logic dev_dout_en, dev_ce_n, dev_oe_n, dev_pgm_n, sup_vpp_hi, sup_vdd_prog;

  always #10 clk = ~clk;

  rom_burn_seq #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_MHZ(CLK_MHZ), .PULSE_US(PULSE_US),
    .SETUP_US(SETUP_US), .HOLD_US(HOLD_US), .OE_DLY_CYC(OE_DLY), .MAX_PULSES(MAXP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass),
    .img_req_valid(img_req_valid), .img_req_ready(img_req_ready), .img_req_addr(img_req_addr),
    .img_rsp_valid(img_rsp_valid), .img_rsp_ready(img_rsp_ready), .img_rsp_data(img_rsp_data),
    .dev_addr(dev_addr), .dev_dout(dev_dout), .dev_dout_en(dev_dout_en), .dev_din(dev_din),
    .dev_ce_n(dev_ce_n), .dev_oe_n(dev_oe_n), .dev_pgm_n(dev_pgm_n),
    .sup_vpp_hi(sup_vpp_hi), .sup_vdd_prog(sup_vdd_prog)
  );

  // Configuration written by the main sequence only.
  logic [DW-1:0] image [N];
  int need [N];
  bit weak_on;
  int weak_a;
  int tok;

  // Device and monitor state written by the monitor only.
  logic [DW-1:0] mem [N];
  int pcount [N];
  int nlow, last_pa, last_tok, mon_total, mon_bad;
  int okc;

  int total, bad;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic mchk(input bit ok, input string req, input string what, input int act, input int exp);
    mon_total++;
    if (!ok) begin
      mon_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Output-enable low time, counted on rising edges.
  always @(posedge clk) okc <= dev_oe_n ? 0 : okc + 1;

  // Device read path: inverted data until output enable has been low long enough.
  always_comb begin
    logic [DW-1:0] rd;
    rd = mem[dev_addr];
    if (weak_on && int'(dev_addr) == weak_a && !sup_vpp_hi) rd = rd ^ 8'h01;
    dev_din = (!dev_oe_n && !dev_ce_n && okc >= OE_DLY - 1) ? rd : ~rd;
  end

  // Monitor, device programming model and image store, all on the falling edge.
  bit pv_req = 0, pv_rdy = 0, pv_rsp = 0, pv_rspr = 0, pend = 0;
  logic [AW-1:0] pv_addr = '0, paddr = '0;
  int bp = 0, stab = 0, lowc = 0, hcnt = 0;
  bit hold_on = 0, bad_ctl = 0, prev_pgm = 1, prev_oe = 1;
  logic [DW-1:0] hold_d = '0;
  logic [AW+DW+3:0] sig_prev = '0;

  initial begin
    last_tok = -1;
    mon_total = 0;
    mon_bad = 0;
    okc = 0;
  end

  always @(negedge clk) begin
    logic [AW+DW+3:0] sig_now;
    int a;
    if (tok != last_tok) begin
      for (int i = 0; i < N; i++) begin mem[i] = 8'hFF; pcount[i] = 0; end
      nlow = 0;
      last_pa = 0;
      last_tok = tok;
    end
    // image store with back-pressure
    if (pv_req && pv_rdy) begin pend = 1; paddr = pv_addr; end
    if (pv_req && !pv_rdy)
      mchk(img_req_valid && img_req_addr == pv_addr, "R11", "request held", int'(img_req_addr), int'(pv_addr));
    if (pv_rsp && pv_rspr) img_rsp_valid = 1'b0;
    if (pend && !img_rsp_valid && (bp % 2 == 0)) begin
      img_rsp_valid = 1'b1;
      img_rsp_data = image[paddr];
      pend = 0;
    end
    bp++;
    img_req_ready = (bp % 3) != 1;
    pv_req = img_req_valid; pv_rdy = img_req_ready; pv_addr = img_req_addr;
    pv_rsp = img_rsp_valid; pv_rspr = img_rsp_ready;

    // setup window before strobe fall
    sig_now = {dev_addr, dev_dout, dev_dout_en, sup_vpp_hi, sup_vdd_prog, dev_ce_n};
    if (sig_now != sig_prev) stab = 0; else stab++;
    sig_prev = sig_now;
    if (prev_pgm && !dev_pgm_n) begin
      mchk(stab >= SCYC, "R2", "setup cycles", stab, SCYC);
      mchk(sup_vpp_hi && sup_vdd_prog, "R2", "supplies at fall", int'({sup_vpp_hi, sup_vdd_prog}), 3);
      lowc = 0;
      bad_ctl = 0;
    end
    if (!dev_pgm_n) begin
      lowc++;
      if (dev_oe_n !== 1'b1 || dev_ce_n !== 1'b0) bad_ctl = 1;
    end
    if (!prev_pgm && dev_pgm_n) begin
      mchk(lowc == PCYC, "R3", "pulse width", lowc, PCYC);
      mchk(!bad_ctl, "R3", "ce/oe during pulse", int'(bad_ctl), 0);
      a = int'(dev_addr);
      mchk(a >= last_pa, "R8", "address order", a, last_pa);
      last_pa = a;
      pcount[a]++;
      if (pcount[a] >= need[a]) mem[a] = mem[a] & dev_dout;
      hold_on = 1;
      hcnt = 0;
      hold_d = dev_dout;
    end
    if (hold_on) begin
      if (dev_dout_en && dev_dout == hold_d) hcnt++;
      else begin
        mchk(hcnt >= HCYC, "R4", "hold cycles", hcnt, HCYC);
        hold_on = 0;
      end
    end
    if (prev_oe && !dev_oe_n) begin
      mchk(!dev_dout_en, "R5", "bus released on read", int'(dev_dout_en), 0);
      if (!sup_vpp_hi) nlow++;
    end
    prev_pgm = dev_pgm_n;
    prev_oe = dev_oe_n;
  end

  task automatic idle_pins(input string req);
    chk(dev_ce_n && dev_oe_n && dev_pgm_n, req, "control pins high",
        int'({dev_ce_n, dev_oe_n, dev_pgm_n}), 7);
    chk(!sup_vpp_hi && !sup_vdd_prog, req, "supply flags low",
        int'({sup_vpp_hi, sup_vdd_prog}), 0);
    chk(!dev_dout_en, req, "bus released", int'(dev_dout_en), 0);
  endtask

  task automatic run_case(input string name, input bit poke);
    int cyc;
    bit failp;
    int expp, exp_reads, sum, got_sum;
    tok++;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done, "R10", "done cleared by start", int'(done), 0);
    cyc = 0;
    while (!done && cyc < 40000) begin
      @(negedge clk);
      cyc++;
      start = (poke && (cyc == 300 || cyc == 301));
    end
    start = 1'b0;
    chk(done, "R10", {name, " done"}, int'(done), 1);
    idle_pins("R12");
    failp = 0;
    sum = 0;
    got_sum = 0;
    for (int a = 0; a < N; a++) begin
      if (failp) expp = 0;
      else if (need[a] > MAXP) begin expp = MAXP; failp = 1; end
      else expp = need[a];
      chk(pcount[a] == expp, (need[a] > MAXP) ? "R7" : "R6", {name, " pulses per address"}, pcount[a], expp);
      if (!failp) chk(mem[a] == image[a], "R6", {name, " device byte"}, int'(mem[a]), int'(image[a]));
      sum += expp;
      got_sum += pcount[a];
    end
    chk(got_sum == sum, "R8", {name, " total pulses"}, got_sum, sum);
    exp_reads = failp ? 0 : (weak_on ? weak_a + 1 : N);
    chk(nlow == exp_reads, "R9", {name, " low-supply reads"}, nlow, exp_reads);
    chk(pass == (!failp && !weak_on), failp ? "R7" : "R9", {name, " result"}, int'(pass),
        int'(!failp && !weak_on));
    repeat (3) @(negedge clk);
    chk(done && pass == (!failp && !weak_on), "R10", {name, " result held"}, int'(done), 1);
  endtask

  initial begin
    total = 0;
    bad = 0;
    tok = 0;
    weak_on = 0;
    weak_a = 0;
    for (int a = 0; a < N; a++) begin image[a] = 8'(a * 37 + 5); need[a] = 1; end
    repeat (4) @(negedge clk);
    chk(!done && !pass, "R1", "status in reset", int'({done, pass}), 0);
    idle_pins("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!done && !img_req_valid, "R1", "after reset", int'({done, img_req_valid}), 0);
    idle_pins("R1");

    run_case("single", 0);

    for (int a = 0; a < N; a++) begin image[a] = 8'((a * 29) ^ 8'hC3); need[a] = a + 1; end
    run_case("ramp", 1);

    for (int a = 0; a < N; a++) need[a] = (a == 3) ? MAXP + 1 : 1;
    run_case("overlimit", 0);

    for (int a = 0; a < N; a++) need[a] = (a == 5) ? MAXP : 1;
    run_case("atlimit", 0);

    for (int a = 0; a < N; a++) need[a] = 1;
    weak_on = 1;
    weak_a = 6;
    run_case("weak", 0);

    weak_on = 0;
    for (int a = 0; a < N; a++) image[a] = a[0] ? 8'hFF : 8'h00;
    run_case("extremes", 0);

    $display("test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total + mon_total + 1, bad + mon_bad + 1);
    $finish;
  end

endmodule